// File: doc/BRIEF.md
# Secure-Flash Test Port with Lockout Recovery

This block is a test access port for a secured flash. It runs the standard JTAG state machine on `tck`/`tms`, shifts data in on `tdi` and out on `tdo` least significant bit first, and decodes a 4-bit instruction. The port serves an identification register, a one-bit pass-through register, a debug read path into the flash, and a 7-bit erase clock-divider register. While the device is secured, any read of the flash through the debug instruction is refused. Identification and pass-through access keep working.

Recovery from a lockout uses the recovery instruction. The host loads the divider register under that instruction and then parks the port in Run-Test/Idle. This raises `erase_req` to the flash controller, which answers with a one-cycle `erase_done` once the whole array, including its configuration field, is blank. Leaving Run-Test/Idle before the answer aborts the erase. A completed erase does not unsecure the device at once. The secure flag is re-read from `cfg_secure` only on a device reset, and it may fall only if two things happened before that reset: the erase completed, and the port then passed through Test-Logic-Reset. A power-on reset reloads the flag from `cfg_secure` directly.

The TAP controller has these states: TLR, RTI, SEL_DR, CAP_DR, SHF_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR, SEL_IR, CAP_IR, SHF_IR, EX1_IR, PAU_IR, EX2_IR and UPD_IR. Each state has the standard pair of exits, one taken when `tms` is 1 and one when it is 0. The recovery sequencer has three states:
- IDLE goes to ARMED when the divider register is updated.
- ARMED goes to ERASE when the port is in RTI. It goes back to IDLE on TLR or UPD_IR.
- ERASE goes to IDLE on `erase_done`, which completes the erase. It also goes to IDLE when the port leaves RTI, which aborts the erase.
- A device reset or a power-on reset forces IDLE.

Top module: `jtag_lockout_ctrl`

## Requirements
- R1: Test-Logic-Reset (after power-on, or after five `tms`=1 clocks) selects the identification opcode 4'h1. That instruction shifts out the 32-bit ID value, LSB first. Capture-IR loads the pattern 4'b0001.
- R2: Opcode 4'hF and every opcode other than 4'h1, 4'h8 and 4'hB select a 1-bit pass-through register. It captures 0, so `tdo` shows the `tdi` stream delayed by one shift.
- R3: Opcode 4'h8 on an unsecured device pulses `flash_rd_req` for exactly one cycle in Capture-DR and captures the 16-bit `flash_rdata` for shifting.
- R4: Opcode 4'h8 on a secured device never raises `flash_rd_req`, and it shifts out all zeros. It sets `access_violation`, which stays set until a device reset or a power-on reset.
- R5: Opcode 4'hB selects the 7-bit divider register. Update-DR copies it to `erase_div`, and Capture-DR reloads the current `erase_div`.
- R6: `erase_req` rises one cycle after the port enters Run-Test/Idle that follows a divider update, and at no other time.
- R7: `erase_req` stays high while the port stays in Run-Test/Idle until `erase_done`. It then drops, and `erase_complete` is set.
- R8: If the port leaves Run-Test/Idle before `erase_done`, `erase_req` drops and `erase_complete` stays 0.
- R9: `secured` is loaded from `cfg_secure` on power-on reset and changes at no time other than a device reset. A device reset clears it only if the erase completed and the port then passed through Test-Logic-Reset. Otherwise it stays set.
- R10: Once `erase_complete` is set, only a device reset or a power-on reset clears it.
- R11: While secured, the identification instruction still returns the ID value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| por_n | input | 1 | Power-on reset, active low, synchronous; resets the port and the device side |
| dev_rst_n | input | 1 | Device reset, active low, synchronous; leaves the port state alone |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out; 0 outside the shift states |
| cfg_secure | input | 1 | Security bit as currently stored in the flash configuration field |
| secured | output | 1 | Current secure flag |
| flash_rdata | input | 16 | Flash read data for the debug path |
| flash_rd_req | output | 1 | One-cycle flash read strobe from the debug path |
| erase_req | output | 1 | Mass-erase request to the flash controller |
| erase_done | input | 1 | One-cycle completion pulse from the flash controller |
| erase_div | output | 7 | Erase clock-divider value |
| erase_complete | output | 1 | Set once a requested erase has completed |
| access_violation | output | 1 | Sticky flag for a refused debug read |

## Verification
The hardest case to reach is the unlock itself. It needs a completed erase, then a trip through Test-Logic-Reset, then a device reset, all in that order. A device reset that comes first wipes the completion and leaves the part secured. The bench first runs the wrong order and checks that `secured` holds. It then repeats the erase, walks the port through Test-Logic-Reset, pulses `dev_rst_n`, and shows that the flag falls and debug reads return flash data again. The abort case is reached by leaving Run-Test/Idle while `erase_req` is high.

// File: rtl/lockout_pkg.sv
`timescale 1ns/1ps
package lockout_pkg;

    localparam int IR_W = 4;

    localparam logic [IR_W-1:0] OP_IDCODE  = 4'h1;
    localparam logic [IR_W-1:0] OP_DEBUG   = 4'h8;
    localparam logic [IR_W-1:0] OP_RECOVER = 4'hB;
    localparam logic [IR_W-1:0] OP_BYPASS  = 4'hF;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    typedef enum logic [1:0] {DR_ID, DR_BYP, DR_DBG, DR_DIV} dr_sel_t;

    typedef enum logic [1:0] {RC_IDLE, RC_ARMED, RC_ERASE} rec_state_t;

endpackage

// File: rtl/lockout_tap_fsm.sv
`timescale 1ns/1ps
module lockout_tap_fsm
    import lockout_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_t state
);

    tap_state_t state_q;
    tap_state_t state_nx;

    always_ff @(posedge tck) begin
        if (!por_n) state_q <= ST_TLR;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_TLR:    state_nx = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    state_nx = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: state_nx = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_nx = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: state_nx = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: state_nx = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_nx = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_nx = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: state_nx = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: state_nx = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: state_nx = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: state_nx = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: state_nx = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_nx = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_nx = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: state_nx = tms ? ST_SEL_DR : ST_RTI;
            default:   state_nx = ST_TLR;
        endcase
    end

    always_comb state = state_q;

endmodule

// File: rtl/lockout_ir.sv
`timescale 1ns/1ps
module lockout_ir
    import lockout_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  tap_state_t state,
    input  logic       tdi,
    output logic       ir_tdo,
    output dr_sel_t    dr_sel
);

    logic [IR_W-1:0] ir_sh;
    logic [IR_W-1:0] ir_q;

    always_ff @(posedge tck) begin
        if (!por_n) begin
            ir_sh <= '0;
            ir_q  <= OP_IDCODE;
        end else begin
            if (state == ST_CAP_IR)      ir_sh <= IR_CAPTURE;
            else if (state == ST_SHF_IR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
            if (state == ST_TLR)         ir_q  <= OP_IDCODE;
            else if (state == ST_UPD_IR) ir_q  <= ir_sh;
        end
    end

    always_comb begin
        case (ir_q)
            OP_IDCODE:  dr_sel = DR_ID;
            OP_DEBUG:   dr_sel = DR_DBG;
            OP_RECOVER: dr_sel = DR_DIV;
            default:    dr_sel = DR_BYP;
        endcase
    end

    always_comb ir_tdo = ir_sh[0];

    // R1: Test-Logic-Reset leaves the identification opcode selected
    p_tlr_loads_idcode_r1: assert property (@(posedge tck) disable iff (!por_n)
        (state == ST_TLR) |=> (ir_q == OP_IDCODE));

endmodule

// File: rtl/lockout_dr_path.sv
`timescale 1ns/1ps
module lockout_dr_path
    import lockout_pkg::*;
#(
    parameter int              ID_W    = 32,
    parameter logic [ID_W-1:0] ID_CODE = 32'h4B1D_6A3F,
    parameter int              DATA_W  = 16,
    parameter int              DIV_W   = 7
) (
    input  logic              tck,
    input  logic              por_n,
    input  logic              dev_rst_n,
    input  tap_state_t        state,
    input  dr_sel_t           dr_sel,
    input  logic              tdi,
    input  logic              secured,
    input  logic [DATA_W-1:0] flash_rdata,
    output logic              dr_tdo,
    output logic              flash_rd_req,
    output logic              div_upd,
    output logic [DIV_W-1:0]  erase_div,
    output logic              access_violation
);

    localparam int DR_W0 = (ID_W > DATA_W) ? ID_W : DATA_W;
    localparam int DR_W  = (DR_W0 > DIV_W) ? DR_W0 : DIV_W;
    localparam int LEN_W = $clog2(DR_W + 1);

    logic [DR_W-1:0]  dr_sh;
    logic [DR_W-1:0]  cap_val;
    logic [DR_W-1:0]  shift_nx;
    logic [LEN_W-1:0] dr_len;
    logic [LEN_W-1:0] msb_idx;
    logic [DIV_W-1:0] div_q;
    logic             viol_q;
    logic             dbg_cap;

    always_comb begin
        case (dr_sel)
            DR_ID:   dr_len = LEN_W'(ID_W);
            DR_DBG:  dr_len = LEN_W'(DATA_W);
            DR_DIV:  dr_len = LEN_W'(DIV_W);
            default: dr_len = LEN_W'(1);
        endcase
        msb_idx = dr_len - LEN_W'(1);
    end

    always_comb begin
        case (dr_sel)
            DR_ID:   cap_val = DR_W'(ID_CODE);
            DR_DBG:  cap_val = secured ? '0 : DR_W'(flash_rdata);
            DR_DIV:  cap_val = DR_W'(div_q);
            default: cap_val = '0;
        endcase
    end

    always_comb begin
        shift_nx          = dr_sh >> 1;
        shift_nx[msb_idx] = tdi;
    end

    always_comb dbg_cap = (state == ST_CAP_DR) && (dr_sel == DR_DBG);

    always_ff @(posedge tck) begin
        if (!por_n) begin
            dr_sh <= '0;
            div_q <= '0;
        end else begin
            if (state == ST_CAP_DR)      dr_sh <= cap_val;
            else if (state == ST_SHF_DR) dr_sh <= shift_nx;
            if (div_upd)                 div_q <= dr_sh[DIV_W-1:0];
        end
    end

    always_ff @(posedge tck) begin
        if (!por_n || !dev_rst_n)   viol_q <= 1'b0;
        else if (dbg_cap && secured) viol_q <= 1'b1;
    end

    always_comb begin
        dr_tdo           = dr_sh[0];
        flash_rd_req     = dbg_cap && !secured;
        div_upd          = (state == ST_UPD_DR) && (dr_sel == DR_DIV);
        erase_div        = div_q;
        access_violation = viol_q;
    end

    // R4: the refusal flag holds until a device reset
    p_violation_sticky_r4: assert property (@(posedge tck) disable iff (!por_n)
        (access_violation && dev_rst_n) |=> access_violation);

    // R5: the divider only changes on its own Update-DR
    p_div_only_on_update_r5: assert property (@(posedge tck) disable iff (!por_n)
        !((state == ST_UPD_DR) && (dr_sel == DR_DIV)) |=> $stable(erase_div));

endmodule

// File: rtl/lockout_recovery.sv
`timescale 1ns/1ps
module lockout_recovery
    import lockout_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       dev_rst_n,
    input  tap_state_t state,
    input  logic       div_upd,
    input  logic       cfg_secure,
    input  logic       erase_done,
    output logic       erase_req,
    output logic       erase_complete,
    output logic       secured
);

    rec_state_t rec_q;
    rec_state_t rec_nx;
    logic       done_q;
    logic       tlr_seen_q;
    logic       sec_q;

    always_ff @(posedge tck) begin
        if (!por_n || !dev_rst_n) rec_q <= RC_IDLE;
        else                      rec_q <= rec_nx;
    end

    always_comb begin
        rec_nx = rec_q;
        unique case (rec_q)
            RC_IDLE:  if (div_upd) rec_nx = RC_ARMED;
            RC_ARMED: begin
                if (state == ST_TLR || state == ST_UPD_IR) rec_nx = RC_IDLE;
                else if (state == ST_RTI)                  rec_nx = RC_ERASE;
            end
            RC_ERASE: begin
                if (erase_done)            rec_nx = RC_IDLE;
                else if (state != ST_RTI)  rec_nx = RC_IDLE;
            end
            default:  rec_nx = RC_IDLE;
        endcase
    end

    always_ff @(posedge tck) begin
        if (!por_n || !dev_rst_n) begin
            done_q     <= 1'b0;
            tlr_seen_q <= 1'b0;
        end else begin
            if (rec_q == RC_ERASE && erase_done) done_q     <= 1'b1;
            if (state == ST_TLR && done_q)       tlr_seen_q <= 1'b1;
        end
    end

    always_ff @(posedge tck) begin
        if (!por_n)          sec_q <= cfg_secure;
        else if (!dev_rst_n) sec_q <= cfg_secure | (sec_q & ~(done_q & tlr_seen_q));
    end

    always_comb begin
        erase_req      = (rec_q == RC_ERASE);
        erase_complete = done_q;
        secured        = sec_q;
    end

    // R6: a request only ever starts out of Run-Test/Idle
    p_start_in_rti_r6: assert property (@(posedge tck) disable iff (!por_n)
        $rose(erase_req) |-> ($past(state) == ST_RTI));

    // R7: the completion pulse ends the request and latches completion
    p_done_latches_r7: assert property (@(posedge tck) disable iff (!por_n)
        (erase_req && erase_done && dev_rst_n) |=> (!erase_req && erase_complete));

    // R8: leaving Run-Test/Idle early aborts the request
    p_abort_on_exit_r8: assert property (@(posedge tck) disable iff (!por_n)
        (erase_req && state != ST_RTI && !erase_done && dev_rst_n) |=> !erase_req);

    // R10: completion survives everything but a reset
    p_complete_sticky_r10: assert property (@(posedge tck) disable iff (!por_n)
        (erase_complete && dev_rst_n) |=> erase_complete);

    // R9: the secure flag moves only under a device reset
    p_secure_only_on_reset_r9: assert property (@(posedge tck) disable iff (!por_n)
        dev_rst_n |=> $stable(secured));

endmodule

// File: rtl/jtag_lockout_ctrl.sv
`timescale 1ns/1ps
module jtag_lockout_ctrl
    import lockout_pkg::*;
#(
    parameter int              ID_W    = 32,
    parameter logic [ID_W-1:0] ID_CODE = 32'h4B1D_6A3F,
    parameter int              DATA_W  = 16,
    parameter int              DIV_W   = 7
) (
    input  logic              tck,
    input  logic              por_n,
    input  logic              dev_rst_n,
    input  logic              tms,
    input  logic              tdi,
    output logic              tdo,
    input  logic              cfg_secure,
    output logic              secured,
    input  logic [DATA_W-1:0] flash_rdata,
    output logic              flash_rd_req,
    output logic              erase_req,
    input  logic              erase_done,
    output logic [DIV_W-1:0]  erase_div,
    output logic              erase_complete,
    output logic              access_violation
);

    tap_state_t state;
    dr_sel_t    dr_sel;
    logic       ir_tdo;
    logic       dr_tdo;
    logic       div_upd;

    lockout_tap_fsm u_tap (
        .tck   (tck),
        .por_n (por_n),
        .tms   (tms),
        .state (state)
    );

    lockout_ir u_ir (
        .tck    (tck),
        .por_n  (por_n),
        .state  (state),
        .tdi    (tdi),
        .ir_tdo (ir_tdo),
        .dr_sel (dr_sel)
    );

    lockout_dr_path #(
        .ID_W    (ID_W),
        .ID_CODE (ID_CODE),
        .DATA_W  (DATA_W),
        .DIV_W   (DIV_W)
    ) u_dr (
        .tck              (tck),
        .por_n            (por_n),
        .dev_rst_n        (dev_rst_n),
        .state            (state),
        .dr_sel           (dr_sel),
        .tdi              (tdi),
        .secured          (secured),
        .flash_rdata      (flash_rdata),
        .dr_tdo           (dr_tdo),
        .flash_rd_req     (flash_rd_req),
        .div_upd          (div_upd),
        .erase_div        (erase_div),
        .access_violation (access_violation)
    );

    lockout_recovery u_rec (
        .tck            (tck),
        .por_n          (por_n),
        .dev_rst_n      (dev_rst_n),
        .state          (state),
        .div_upd        (div_upd),
        .cfg_secure     (cfg_secure),
        .erase_done     (erase_done),
        .erase_req      (erase_req),
        .erase_complete (erase_complete),
        .secured        (secured)
    );

    always_comb begin
        if (state == ST_SHF_IR)      tdo = ir_tdo;
        else if (state == ST_SHF_DR) tdo = dr_tdo;
        else                         tdo = 1'b0;
    end

endmodule

// File: tb/jtag_lockout_ctrl_tb.sv
`timescale 1ns/1ps
module jtag_lockout_ctrl_tb_top;

    localparam logic [31:0] TB_ID   = 32'h4B1D_6A3F;
    localparam logic [15:0] TB_DATA = 16'hC3A5;

    logic        tck = 1'b0;
    logic        por_n, dev_rst_n, tms, tdi, tdo;
    logic        cfg_secure, secured, flash_rd_req;
    logic [15:0] flash_rdata;
    logic        erase_req, erase_done, erase_complete, access_violation;
    logic [6:0]  erase_div;

    int n_chk   = 0;
    int n_fail  = 0;
    int rd_cnt  = 0;
    bit finished = 1'b0;

    always #2 tck = ~tck;

    jtag_lockout_ctrl #(.ID_CODE(TB_ID)) dut_i (
        .tck(tck), .por_n(por_n), .dev_rst_n(dev_rst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .cfg_secure(cfg_secure), .secured(secured),
        .flash_rdata(flash_rdata), .flash_rd_req(flash_rd_req),
        .erase_req(erase_req), .erase_done(erase_done), .erase_div(erase_div),
        .erase_complete(erase_complete), .access_violation(access_violation)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one TAP clock; inputs change and outputs are sampled at the falling edge
    task automatic step(input logic t, input logic d);
        if (flash_rd_req) rd_cnt++;
        tms = t;
        tdi = d;
        @(negedge tck);
    endtask

    task automatic tap_reset();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic load_ir(input logic [3:0] op, output logic [3:0] cap);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            cap[i] = tdo;
            step(i == 3, op[i]);
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    task automatic shift_dr(input int len, input logic [31:0] din, input bit detour,
                            output logic [31:0] dout, output bit req_seen);
        dout = '0;
        req_seen = 1'b0;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < len; i++) begin
            dout[i] = tdo;
            step(i == len - 1, din[i]);
        end
        step(1'b1, 1'b0);
        if (detour) begin
            step(1'b1, 1'b0);
            req_seen = req_seen | erase_req;
            step(1'b0, 1'b0);
            step(1'b1, 1'b0);
            for (int i = 0; i < 3; i++) begin
                step(1'b0, 1'b0);
                req_seen = req_seen | erase_req;
            end
            step(1'b1, 1'b0);
            step(1'b1, 1'b0);
        end
        step(1'b0, 1'b0);
    endtask

    task automatic dev_reset();
        dev_rst_n = 1'b0;
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
        dev_rst_n = 1'b1;
        step(1'b0, 1'b0);
    endtask

    task automatic por(input logic sec);
        cfg_secure = sec;
        por_n = 1'b0;
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        por_n = 1'b1;
        step(1'b0, 1'b0);
    endtask

    // starts from RTI with the divider freshly loaded; runs an erase to completion
    task automatic finish_erase(input string tag);
        step(1'b0, 1'b0);
        chk(erase_req == 1'b1, {tag, " R6 request after RTI entry"}, 32'(erase_req), 32'd1);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
        chk(erase_req == 1'b1, {tag, " R7 request held in RTI"}, 32'(erase_req), 32'd1);
        erase_done = 1'b1;
        step(1'b0, 1'b0);
        erase_done = 1'b0;
        chk(erase_req == 1'b0, {tag, " R7 request drops on done"}, 32'(erase_req), 32'd0);
        chk(erase_complete == 1'b1, {tag, " R7 complete latched"}, 32'(erase_complete), 32'd1);
    endtask

    task automatic t_reset_and_id();
        logic [31:0] d;
        logic [3:0]  c;
        bit          r;
        por(1'b0);
        chk(secured == 1'b0, "R9 unsecured after POR", 32'(secured), 32'd0);
        chk(erase_req == 1'b0 && erase_complete == 1'b0 && access_violation == 1'b0,
            "R10 reset state", {29'd0, erase_req, erase_complete, access_violation}, 32'd0);
        shift_dr(32, 32'h0, 1'b0, d, r);
        chk(d == TB_ID, "R1 ID after POR", d, TB_ID);
        load_ir(4'hF, c);
        chk(c == 4'b0001, "R1 IR capture pattern", 32'(c), 32'd1);
        tap_reset();
        shift_dr(32, 32'h0, 1'b0, d, r);
        chk(d == TB_ID, "R1 ID after TLR", d, TB_ID);
    endtask

    task automatic t_bypass();
        logic [31:0] d;
        logic [3:0]  c;
        bit          r;
        load_ir(4'hF, c);
        shift_dr(8, 32'hB2, 1'b0, d, r);
        chk(d[7:0] == 8'h64, "R2 bypass 4'hF", 32'(d[7:0]), 32'h64);
        load_ir(4'h5, c);
        shift_dr(8, 32'h4D, 1'b0, d, r);
        chk(d[7:0] == 8'h9A, "R2 undefined opcode bypass", 32'(d[7:0]), 32'h9A);
    endtask

    task automatic t_debug_open(input string tag);
        logic [31:0] d;
        logic [3:0]  c;
        bit          r;
        load_ir(4'h8, c);
        rd_cnt = 0;
        shift_dr(16, 32'h0, 1'b0, d, r);
        chk(d[15:0] == TB_DATA, {tag, " R3 debug read data"}, 32'(d[15:0]), 32'(TB_DATA));
        chk(rd_cnt == 1, {tag, " R3 single read strobe"}, 32'(rd_cnt), 32'd1);
        chk(access_violation == 1'b0, {tag, " R3 no violation"}, 32'(access_violation), 32'd0);
    endtask

    task automatic t_divider_and_abort();
        logic [31:0] d;
        logic [3:0]  c;
        bit          r;
        load_ir(4'hB, c);
        shift_dr(7, 32'h5A, 1'b1, d, r);
        chk(erase_div == 7'h5A, "R5 divider updated", 32'(erase_div), 32'h5A);
        chk(r == 1'b0, "R6 no request outside RTI", 32'(r), 32'd0);
        step(1'b0, 1'b0);
        chk(erase_req == 1'b1, "R6 request after RTI entry", 32'(erase_req), 32'd1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        chk(erase_req == 1'b0, "R8 abort drops request", 32'(erase_req), 32'd0);
        chk(erase_complete == 1'b0, "R8 abort leaves incomplete", 32'(erase_complete), 32'd0);
        tap_reset();
        load_ir(4'hB, c);
        shift_dr(7, 32'h11, 1'b0, d, r);
        chk(d[6:0] == 7'h5A, "R5 divider capture", 32'(d[6:0]), 32'h5A);
        finish_erase("open");
        tap_reset();
        step(1'b0, 1'b0);
        chk(erase_complete == 1'b1, "R10 complete survives TLR", 32'(erase_complete), 32'd1);
        dev_reset();
        chk(erase_complete == 1'b0, "R10 cleared by device reset", 32'(erase_complete), 32'd0);
    endtask

    task automatic t_secure_unlock();
        logic [31:0] d;
        logic [3:0]  c;
        bit          r;
        por(1'b1);
        chk(secured == 1'b1, "R9 secured after POR", 32'(secured), 32'd1);
        shift_dr(32, 32'h0, 1'b0, d, r);
        chk(d == TB_ID, "R11 ID while secured", d, TB_ID);
        load_ir(4'h8, c);
        rd_cnt = 0;
        shift_dr(16, 32'h0, 1'b0, d, r);
        chk(d[15:0] == 16'h0, "R4 blocked read shifts zeros", 32'(d[15:0]), 32'h0);
        chk(rd_cnt == 0, "R4 no read strobe", 32'(rd_cnt), 32'd0);
        tap_reset();
        chk(access_violation == 1'b1, "R4 violation sticky", 32'(access_violation), 32'd1);
        // wrong order: erase then device reset with no TLR in between
        load_ir(4'hB, c);
        shift_dr(7, 32'h20, 1'b0, d, r);
        finish_erase("secure1");
        cfg_secure = 1'b0;
        dev_reset();
        chk(secured == 1'b1, "R9 stays secured without TLR", 32'(secured), 32'd1);
        chk(access_violation == 1'b0, "R4 violation cleared by reset", 32'(access_violation), 32'd0);
        // right order: erase, TLR, device reset
        load_ir(4'hB, c);
        shift_dr(7, 32'h20, 1'b0, d, r);
        finish_erase("secure2");
        tap_reset();
        chk(secured == 1'b1, "R9 secured until device reset", 32'(secured), 32'd1);
        dev_reset();
        chk(secured == 1'b0, "R9 unsecured after erase+TLR+reset", 32'(secured), 32'd0);
        t_debug_open("unlocked");
    endtask

    initial begin
        por_n = 1'b0; dev_rst_n = 1'b1; tms = 1'b1; tdi = 1'b0;
        cfg_secure = 1'b0; erase_done = 1'b0; flash_rdata = TB_DATA;
        @(negedge tck);
        t_reset_and_id();
        t_bypass();
        t_debug_open("open");
        t_divider_and_abort();
        t_secure_unlock();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule